// File: doc/BRIEF.md
# Banked GPIO Controller with Change Interrupt

This block drives and samples 40 general-purpose pins grouped as five banks of eight. Each bank has four byte-wide registers behind a simple read/write register port: a direction register, an interrupt-mask register, an output latch, and a read-only input port. A pin whose direction bit is 0 is an output: its output enable is asserted and it carries the latch value. A pin whose direction bit is 1 is an input. Input pins pass through a two-flop synchroniser before anything else uses them.

Each bank keeps a snapshot of its synchronised inputs. When an input pin with a clear mask bit differs from its snapshot, the shared active-low interrupt asserts. Software reads that bank's input-port register, which returns the synchronised pins and copies them into the snapshot. This clears the pending change for that bank only. An asynchronous active-low reset returns every register to its default.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every direction byte reads FFh, every mask byte reads FFh, every output latch reads 00h, all output enables are low and the interrupt output is high.
- R2: A write to a direction register (18h + bank), a mask register (20h + bank) or an output latch (08h + bank) is returned unchanged by a later read of the same address.
- R3: Pin bit (8*bank + i) has its output enable high exactly when bit i of that bank's direction byte is 0, and its output data equals bit i of that bank's output latch.
- R4: A read of address 00h + bank returns that bank's pins as sampled through two flops, so a pin change is visible on a read issued two clock edges after it.
- R5: The interrupt output is low while any pin has direction bit 1, mask bit 0, and a synchronised value that differs from its bank's snapshot.
- R6: A change on a pin whose mask bit is 1 does not pull the interrupt output low.
- R7: A change on a pin whose direction bit is 0 does not pull the interrupt output low.
- R8: A read of address 00h + bank loads that bank's snapshot with the value returned. Pending changes in the other banks are left as they are.
- R9: A read of any unmapped address returns 00h. A write to an unmapped address changes no register.
- R10: While the reset input is low, register writes are ignored, and after release all registers hold their R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; also the snapshot load for input-port addresses |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational, valid while reg_rd_en is high |
| pin_in | input | 40 | Pin input levels |
| pin_out | output | 40 | Pin output data |
| pin_oe | output | 40 | Pin output enables, active high |
| irq_n | output | 1 | Shared active-low change interrupt |

## Verification
The bench unmasks a single pin and toggles it. A design that ignored the mask would also assert on the neighbouring masked pin. The bench also switches an unmasked pin to output and toggles it. Logic that forgot the direction qualifier would fire there, and the bench then restores the pin to input so that the old difference against the snapshot surfaces.

For snapshot isolation, two banks hold pending changes and only one bank is read. A design that cleared every bank on any read would raise the interrupt early. Probes of unmapped addresses just beyond each bank window show off-by-one decode as a stray read value or a corrupted register. Writes issued during reset show whether reset truly holds the register file.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int N_PINS    = NUM_BANKS * BANK_W;

  localparam logic [ADDR_W-1:0] IN_BASE  = 8'h00;
  localparam logic [ADDR_W-1:0] OUT_BASE = 8'h08;
  localparam logic [ADDR_W-1:0] DIR_BASE = 8'h18;
  localparam logic [ADDR_W-1:0] MSK_BASE = 8'h20;

  // Address hit for bank b in the window starting at base.
  function automatic logic bank_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base, input int b);
    return a == (base + ADDR_W'(b));
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return (a >= base) && (a < base + ADDR_W'(NUM_BANKS));
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return in_window(a, IN_BASE) || in_window(a, OUT_BASE) ||
           in_window(a, DIR_BASE) || in_window(a, MSK_BASE);
  endfunction

  // Pending change per pin: input, unmasked, differs from snapshot.
  function automatic logic [BANK_W-1:0] pend_bits(input logic [BANK_W-1:0] diff,
                                                   input logic [BANK_W-1:0] dir,
                                                   input logic [BANK_W-1:0] msk);
    return diff & dir & ~msk;
  endfunction
endpackage

// File: rtl/gpio_inbank.sv
module gpio_inbank
  import gpio_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         snap_ld,
  output logic [W-1:0] sync_val,
  output logic [W-1:0] change
);
  logic [W-1:0] meta_q, sync_q, snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      snap_q <= '0;
    end else begin
      meta_q <= pins;
      sync_q <= meta_q;
      if (snap_ld) snap_q <= sync_q;
    end
  end

  assign sync_val = sync_q;
  assign change   = sync_q ^ snap_q;

  // R8: after a load, the only differences are pins that moved since.
  a_r8_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ld |=> change == ($past(sync_val) ^ sync_val));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [N_PINS-1:0] in_sync,
  output logic [BANK_W-1:0] rdata,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] mask_q,
  output logic [N_PINS-1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      mask_q <= '1;
      out_q  <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_hit(addr, DIR_BASE, b)) dir_q[b*BANK_W +: BANK_W]  <= wdata;
        if (bank_hit(addr, MSK_BASE, b)) mask_q[b*BANK_W +: BANK_W] <= wdata;
        if (bank_hit(addr, OUT_BASE, b)) out_q[b*BANK_W +: BANK_W]  <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bank_hit(addr, IN_BASE, b))  rdata = in_sync[b*BANK_W +: BANK_W];
        if (bank_hit(addr, OUT_BASE, b)) rdata = out_q[b*BANK_W +: BANK_W];
        if (bank_hit(addr, DIR_BASE, b)) rdata = dir_q[b*BANK_W +: BANK_W];
        if (bank_hit(addr, MSK_BASE, b)) rdata = mask_q[b*BANK_W +: BANK_W];
      end
    end
  end

  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mapped(addr)) |-> rdata == '0);
  a_r9_unmapped_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_mapped(addr)) |=> ($stable(dir_q) && $stable(mask_q) && $stable(out_q)));
  a_r2_dir_write_b0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR_BASE) |=> dir_q[BANK_W-1:0] == $past(wdata));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_n
);
  logic [N_PINS-1:0] in_sync, change_v, pend_v, dir_q, mask_q, out_q;
  logic [NUM_BANKS-1:0] snap_ld;

  gpio_regfile i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .in_sync(in_sync), .rdata(reg_rdata),
    .dir_q(dir_q), .mask_q(mask_q), .out_q(out_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign snap_ld[b] = reg_rd_en && bank_hit(reg_addr, IN_BASE, b);
    gpio_inbank #(.W(BANK_W)) i_in (
      .clk(clk), .rst_n(rst_n), .pins(pin_in[b*BANK_W +: BANK_W]),
      .snap_ld(snap_ld[b]), .sync_val(in_sync[b*BANK_W +: BANK_W]),
      .change(change_v[b*BANK_W +: BANK_W])
    );
    assign pend_v[b*BANK_W +: BANK_W] = pend_bits(change_v[b*BANK_W +: BANK_W],
      dir_q[b*BANK_W +: BANK_W], mask_q[b*BANK_W +: BANK_W]);
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq_n   = ~|pend_v;

  a_r1_release_defaults: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n && pin_oe == '0 && pin_out == '0));
  a_r7_irq_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> |(~pin_oe & ~mask_q));
  a_r6_irq_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> irq_n);
endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [39:0] pin_in = 0, pin_out, pin_oe;
  logic irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n)
  );

  // Behavioural reference model
  logic [7:0] m_dir[5], m_msk[5], m_out[5], m_s1[5], m_s2[5], m_snap[5];

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int k;
    k = int'(a[2:0]);
    if (a <= 8'h04) return m_s2[k];
    if (a >= 8'h08 && a <= 8'h0C) return m_out[k];
    if (a >= 8'h18 && a <= 8'h1C) return m_dir[k];
    if (a >= 8'h20 && a <= 8'h24) return m_msk[k];
    return 8'h00;
  endfunction

  function automatic logic m_irq();
    for (int k = 0; k < 5; k++)
      if (((m_s2[k] ^ m_snap[k]) & m_dir[k] & ~m_msk[k]) != 0) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin
        m_dir[k] = 8'hFF; m_msk[k] = 8'hFF; m_out[k] = 8'h00;
        m_s1[k] = 0; m_s2[k] = 0; m_snap[k] = 0;
      end
    end else begin
      if (rd_en && addr <= 8'h04) m_snap[addr[2:0]] = m_s2[addr[2:0]];
      if (wr_en) begin
        if (addr >= 8'h08 && addr <= 8'h0C) m_out[addr[2:0]] = wdata;
        if (addr >= 8'h18 && addr <= 8'h1C) m_dir[addr[2:0]] = wdata;
        if (addr >= 8'h20 && addr <= 8'h24) m_msk[addr[2:0]] = wdata;
      end
      for (int k = 0; k < 5; k++) begin
        m_s2[k] = m_s1[k];
        m_s1[k] = pin_in[k*8 +: 8];
      end
    end
  end

  task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Model compare on every clock, mid-cycle
  always @(negedge clk) if (!done) begin
    logic [39:0] e_oe, e_out;
    for (int k = 0; k < 5; k++) begin
      e_oe[k*8 +: 8]  = ~m_dir[k];
      e_out[k*8 +: 8] = m_out[k];
    end
    chk(pin_oe, e_oe, "R3 oe model");
    chk(pin_out, e_out, "R3 out model");
    chk({39'd0, irq_n}, {39'd0, m_irq()}, "R5 irq model");
    if (rd_en) chk({32'd0, rdata}, {32'd0, m_read(addr)}, "R2 rdata model");
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1; rd_en = 1; addr = a;
    @(negedge clk); chk({32'd0, rdata}, {32'd0, exp}, req);
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk); chk({39'd0, irq_n}, {39'd0, exp}, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R10: writes during reset are ignored
    idle(2);
    do_write(8'h18, 8'h00);
    do_write(8'h08, 8'hAA);
    idle(1); rst_n = 1; idle(1);
    // R1 defaults
    chk(pin_oe, 40'h0, "R1 oe default");
    chk(pin_out, 40'h0, "R1 out default");
    chk_irq(1'b1, "R1 irq default");
    do_read(8'h18, 8'hFF, "R10 dir kept default");
    do_read(8'h08, 8'h00, "R10 out kept default");
    do_read(8'h24, 8'hFF, "R1 mask default");
    // R2 / R3
    do_write(8'h18, 8'h00); do_write(8'h08, 8'h5A);
    do_write(8'h1C, 8'h0F); do_write(8'h0C, 8'h3C);
    do_read(8'h18, 8'h00, "R2 dir b0");
    do_read(8'h0C, 8'h3C, "R2 out b4");
    do_read(8'h1C, 8'h0F, "R2 dir b4");
    chk(pin_oe, 40'hF0_0000_00FF, "R3 oe pattern");
    chk(pin_out, 40'h3C_0000_005A, "R3 out pattern");
    // R4 synchroniser
    pin_in[23:16] = 8'hA5; idle(3);
    do_read(8'h02, 8'hA5, "R4 sync read b2");
    // R5: unmask pin 11
    do_write(8'h21, 8'hF7);
    do_read(8'h01, 8'h00, "R4 b1 baseline");
    pin_in[11] = 1; idle(3);
    chk_irq(1'b0, "R5 unmasked change");
    do_read(8'h01, 8'h08, "R8 read b1");
    chk_irq(1'b1, "R8 read clears");
    // R6: masked pin 12
    pin_in[12] = 1; idle(3);
    chk_irq(1'b1, "R6 masked change");
    // R7: pin 11 as output
    do_write(8'h19, 8'hF7);
    pin_in[11] = 0; idle(3);
    chk_irq(1'b1, "R7 output pin change");
    do_write(8'h19, 8'hFF);
    chk_irq(1'b0, "R5 latent change after dir restore");
    do_read(8'h01, 8'h10, "R8 read b1 again");
    chk_irq(1'b1, "R8 cleared again");
    // R8 bank isolation
    do_write(8'h23, 8'hFE);
    pin_in[24] = 1; pin_in[11] = 1; idle(3);
    chk_irq(1'b0, "R8 two pending");
    do_read(8'h01, 8'h18, "R8 read b1 only");
    chk_irq(1'b0, "R8 b3 still pending");
    do_read(8'h03, 8'h01, "R8 read b3");
    chk_irq(1'b1, "R8 all cleared");
    // R9 unmapped
    do_read(8'h05, 8'h00, "R9 read 05");
    do_read(8'h1D, 8'h00, "R9 read 1D");
    do_read(8'hFF, 8'h00, "R9 read FF");
    do_write(8'h0D, 8'hAA); do_write(8'h25, 8'h00); do_write(8'h1D, 8'h00);
    do_read(8'h0C, 8'h3C, "R9 out b4 untouched");
    do_read(8'h24, 8'hFF, "R9 mask b4 untouched");
    do_read(8'h1C, 8'h0F, "R9 dir b4 untouched");
    chk_irq(1'b1, "R9 irq untouched");
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule